// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral for up to 71 pins. The pins are grouped into banks of 32. Each bank is reached through ten 32-bit words on a simple register bus, which carries a byte address, a write strobe, write data and combinational read data. Software picks the pin direction and the driven level. The driven level can be changed either by a plain write or through separate set-only and clear-only words, so several pins can change in one access without a read-modify-write.

Pin levels enter through a two-flop synchronizer. The synchronized value is what software reads back, for output pins as well as input pins, which allows wired-logic use. Each pin has its own rising-edge and falling-edge detection enables. An enabled edge latches a sticky status bit, and that bit drives the pin's own interrupt line until software writes a one to it.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: During reset and right after it, every direction bit is 1, so `pin_oe` is all zero. The output data, both edge-enable sets and all status bits are zero, and `irq` is all zero.
- R2: Bank b starts at byte address 0x10 + 0x28*b. Word k of a bank (k = 0..9) is at base + 4*k, in the order: direction, output data, set data, clear data, input data, set rising, clear rising, set falling, clear falling, status. Pin N is bit N mod 32 of bank N/32. The two lowest address bits do not select a word.
- R3: A direction bit of 1 makes its pin an input (`pin_oe` low). A direction bit of 0 raises `pin_oe`, and `pin_out` carries the output data bit. Writes to the direction word and the output data word replace the whole register after one clock edge.
- R4: Writing the set data word ORs the written mask into output data. Writing the clear data word clears the masked bits. Zero bits leave their pins unchanged. Reads of either word return output data.
- R5: The input data word returns the pin level after two clock edges; it returns the old level before that. The pin level is returned whatever the pin's direction, even when it differs from the driven value.
- R6: Rising and falling detection are enabled per pin by writing ones to the matching set word and disabled by writing ones to the matching clear word. Both may be on for one pin. Reads of either word of a pair return the current enable register.
- R7: An enabled edge on a pin sets that pin's status bit, and `irq` for the pin goes high on the third rising clock edge after the pin changes. Edges on pins with detection disabled set nothing.
- R8: Writing 1 to a status bit clears it and its `irq`. Zero bits are left alone. If an enabled edge lands in the same cycle as the clear, the bit stays set.
- R9: In the last bank only bits 0 to 6 exist. The other bits read as zero and ignore writes.
- R10: Addresses below 0x10 or at and above 0x88 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 71 | Pin levels, asynchronous |
| pin_out | output | 71 | Output data driven toward the pins |
| pin_oe | output | 71 | Per-pin output enable, high = drive |
| irq | output | 71 | Per-pin interrupt, high while the status bit is set |

## Verification
Register effects follow one clock edge after the write is sampled. Read data depends only on the address in the same cycle. A pin change reaches the input data word after two edges and an enabled edge reaches `irq` after three. The bench changes inputs on the falling edge and compares every output against a behavioural reference one nanosecond after each rising edge. The directed checks count edges explicitly: they sample the input word after one edge and after two, `irq` after two edges and after three, and they time a status clear so that it is sampled on the very edge where a new event lands.

// File: rtl/gpio_pkg.sv
// Shared definitions for the banked GPIO controller.
// Assumes each bank decodes a 4-bit word index taken from its local offset.
package gpio_pkg;

    localparam int WORDS_PER_BANK = 10;
    localparam int IDX_W          = 4;

    // Word order inside a bank; status is the last word.
    typedef enum logic [IDX_W-1:0] {
        W_DIR  = 4'd0,
        W_OUT  = 4'd1,
        W_SET  = 4'd2,
        W_CLR  = 4'd3,
        W_IN   = 4'd4,
        W_RSET = 4'd5,
        W_RCLR = 4'd6,
        W_FSET = 4'd7,
        W_FCLR = 4'd8,
        W_STAT = 4'd9
    } word_e;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift the pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/gpio_edge.sv
// Edge detector: compares the synchronized level with its value one cycle ago.
// Assumes lvl is already synchronous to clk.
module gpio_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl;
        end
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

endmodule

// File: rtl/gpio_bank.sv
// One bank of GPIO registers: direction, output data with set/clear aliases,
// synchronized input, rising/falling enables and write-one-to-clear status.
// Assumes wr_en is already qualified by the bank's address decode and that
// idx is in the range 0..9.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic [W-1:0]     irq
);

    logic [W-1:0] lvl;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] ren_q;
    logic [W-1:0] fen_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] events;
    logic [W-1:0] stat_clr;
    logic         wr_dir, wr_out, wr_set, wr_clr;
    logic         wr_rset, wr_rclr, wr_fset, wr_fclr, wr_stat;

    gpio_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    gpio_edge #(.W(W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    // Decode the write strobe into one strobe per word.
    always_comb begin
        wr_dir  = wr_en && (idx == W_DIR);
        wr_out  = wr_en && (idx == W_OUT);
        wr_set  = wr_en && (idx == W_SET);
        wr_clr  = wr_en && (idx == W_CLR);
        wr_rset = wr_en && (idx == W_RSET);
        wr_rclr = wr_en && (idx == W_RCLR);
        wr_fset = wr_en && (idx == W_FSET);
        wr_fclr = wr_en && (idx == W_FCLR);
        wr_stat = wr_en && (idx == W_STAT);
    end

    // Direction register; all pins start as inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (wr_dir) begin
            dir_q <= wdata;
        end
    end

    // Output data: plain write, or masked set / masked clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_out) begin
            out_q <= wdata;
        end else if (wr_set) begin
            out_q <= out_q | wdata;
        end else if (wr_clr) begin
            out_q <= out_q & ~wdata;
        end
    end

    // Rising-edge enables, changed only through their set/clear pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren_q <= '0;
        end else if (wr_rset) begin
            ren_q <= ren_q | wdata;
        end else if (wr_rclr) begin
            ren_q <= ren_q & ~wdata;
        end
    end

    // Falling-edge enables, changed only through their set/clear pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fen_q <= '0;
        end else if (wr_fset) begin
            fen_q <= fen_q | wdata;
        end else if (wr_fclr) begin
            fen_q <= fen_q & ~wdata;
        end
    end

    // Qualify detected edges and form the status clear mask.
    always_comb begin
        events   = (rise & ren_q) | (fall & fen_q);
        stat_clr = wr_stat ? wdata : '0;
    end

    // Sticky status: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | events;
        end
    end

    // Read mux; set/clear aliases return the register they modify.
    always_comb begin
        case (idx)
            W_DIR:                 rdata = dir_q;
            W_OUT, W_SET, W_CLR:   rdata = out_q;
            W_IN:                  rdata = lvl;
            W_RSET, W_RCLR:        rdata = ren_q;
            W_FSET, W_FCLR:        rdata = fen_q;
            W_STAT:                rdata = stat_q;
            default:               rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
    assign irq     = stat_q;

endmodule

// File: rtl/gpio_banked_ctrl.sv
// Top of the banked GPIO controller: decodes the byte address into banks
// of ten words, instantiates one bank per group of BANK_W pins (the last
// one narrower when NUM_PINS is not a multiple) and merges read data.
// Assumes BASE_ADDR + NUM_BANKS*stride fits in ADDR_W bits.
module gpio_banked_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS  = 71,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [BANK_W-1:0]   wdata,
    output logic [BANK_W-1:0]   rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] irq
);

    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int STRIDE    = WORDS_PER_BANK * 4;

    logic [BANK_W-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO    = b * BANK_W;
        localparam int BW    = (NUM_PINS - LO < BANK_W) ? (NUM_PINS - LO) : BANK_W;
        localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(BASE_ADDR + b * STRIDE);
        localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);

        logic [ADDR_W-1:0] off;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [BW-1:0]     rd;

        // Local offset, bank hit and word index.
        always_comb begin
            off = addr - BASE_V;
            hit = (addr >= BASE_V) && (off < STRIDE_V);
            idx = IDX_W'(off >> 2);
        end

        gpio_bank #(.W(BW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && hit),
            .idx     (idx),
            .wdata   (wdata[BW-1:0]),
            .rdata   (rd),
            .pin_in  (pin_in[LO+BW-1:LO]),
            .pin_out (pin_out[LO+BW-1:LO]),
            .pin_oe  (pin_oe[LO+BW-1:LO]),
            .irq     (irq[LO+BW-1:LO])
        );

        // Zero-extend this bank's read data and gate it by the hit.
        always_comb begin
            bank_rd[b] = hit ? BANK_W'(rd) : '0;
        end
    end

    // Merge bank read data; at most one bank hits.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rdata = rdata | bank_rd[b];
        end
    end

endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
// Assertion checker for the banked GPIO controller, bound to the top.
// Assumes NUM_PINS >= BANK_W so the first bank is full width.
module gpio_banked_ctrl_chk #(
    parameter int NUM_PINS  = 71,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic [BANK_W-1:0]   wdata,
    input logic [BANK_W-1:0]   rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] irq
);

    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int STRIDE    = 40;
    localparam int LAST_W    = NUM_PINS - (NUM_BANKS - 1) * BANK_W;
    localparam logic [ADDR_W-1:0] A_DIR0 = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BASE_ADDR + 8);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BASE_ADDR + 12);
    localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(BASE_ADDR + (NUM_BANKS - 1) * STRIDE);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(BASE_ADDR + NUM_BANKS * STRIDE);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && irq == '0)); // R1

    AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR0) |=> (pin_oe[BANK_W-1:0] == ~$past(wdata))); // R3

    AST_SET_ORS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SET0) |=> ((pin_out[BANK_W-1:0] & $past(wdata)) == $past(wdata))); // R4

    AST_CLR_DROPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CLR0) |=> ((pin_out[BANK_W-1:0] & $past(wdata)) == '0)); // R4

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < A_LOW || addr >= A_END) |-> (rdata == '0)); // R10

    if (LAST_W < BANK_W) begin : g_pad
        AST_LAST_BANK_PAD: assert property (@(posedge clk) disable iff (!rst_n)
            (addr >= A_LAST && addr < A_END) |-> (rdata[BANK_W-1:LAST_W] == '0)); // R9
    end

endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(
    .NUM_PINS  (NUM_PINS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/gpio_banked_ctrl_tb.sv
`timescale 1ns/1ps
// Testbench: behavioural per-pin reference model compared after every
// rising edge, plus directed checks on timing and corner cases.
module gpio_banked_ctrl_tb;

    localparam int NP = 71;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    addr;
    logic          wr_en;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    // Reference model state, one entry per pin.
    logic m_dir [NP];
    logic m_out [NP];
    logic m_ren [NP];
    logic m_fen [NP];
    logic m_st  [NP];
    logic m_s1  [NP];
    logic m_s2  [NP];
    logic m_pv  [NP];

    always #2 clk = ~clk;

    gpio_banked_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    function automatic logic [31:0] mread(input logic [7:0] a);
        logic [31:0] r;
        int off, b, w, p;
        r = '0;
        if (a >= 8'h10 && a < 8'h88) begin
            off = int'(a) - 16;
            b   = off / 40;
            w   = (off % 40) / 4;
            for (int i = 0; i < 32; i++) begin
                p = b * 32 + i;
                if (p < NP) begin
                    case (w)
                        0:       r[i] = m_dir[p];
                        1, 2, 3: r[i] = m_out[p];
                        4:       r[i] = m_s2[p];
                        5, 6:    r[i] = m_ren[p];
                        7, 8:    r[i] = m_fen[p];
                        9:       r[i] = m_st[p];
                        default: r[i] = 1'b0;
                    endcase
                end
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update on each rising edge, then compare every output.
    always @(posedge clk) begin
        int off, b, w;
        logic d, ev, hitw;
        logic [NP-1:0] e_out, e_oe, e_irq;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_dir[p] = 1'b1; m_out[p] = 1'b0; m_ren[p] = 1'b0; m_fen[p] = 1'b0;
                m_st[p] = 1'b0;  m_s1[p] = 1'b0;  m_s2[p] = 1'b0;  m_pv[p] = 1'b0;
            end
        end else begin
            hitw = wr_en && addr >= 8'h10 && addr < 8'h88;
            off  = int'(addr) - 16;
            b    = hitw ? off / 40 : -1;
            w    = hitw ? (off % 40) / 4 : -1;
            for (int p = 0; p < NP; p++) begin
                d  = (p / 32 == b) ? wdata[p % 32] : 1'b0;
                ev = (m_s2[p] && !m_pv[p] && m_ren[p]) || (!m_s2[p] && m_pv[p] && m_fen[p]);
                m_st[p] = ev || (m_st[p] && !(w == 9 && d));
                if (p / 32 == b) begin
                    case (w)
                        0: m_dir[p] = d;
                        1: m_out[p] = d;
                        2: if (d) m_out[p] = 1'b1;
                        3: if (d) m_out[p] = 1'b0;
                        5: if (d) m_ren[p] = 1'b1;
                        6: if (d) m_ren[p] = 1'b0;
                        7: if (d) m_fen[p] = 1'b1;
                        8: if (d) m_fen[p] = 1'b0;
                        default: ;
                    endcase
                end
                m_pv[p] = m_s2[p];
                m_s2[p] = m_s1[p];
                m_s1[p] = pin_in[p];
            end
        end
        #1;
        for (int p = 0; p < NP; p++) begin
            e_out[p] = m_out[p];
            e_oe[p]  = ~m_dir[p];
            e_irq[p] = m_st[p];
        end
        checks++;
        if (pin_out !== e_out || pin_oe !== e_oe) begin
            errors++;
            $display("FAIL R3 model pins out=%h/%h oe=%h/%h", pin_out, e_out, pin_oe, e_oe);
        end
        checks++;
        if (irq !== e_irq) begin
            errors++;
            $display("FAIL R7 model irq actual=%h expected=%h", irq, e_irq);
        end
        chk("R2 model rdata", rdata, mread(addr));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1;
        chk(tag, rdata, exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1;
        chk("R1 oe after reset", 32'(pin_oe[31:0]), 32'h0);
        chk("R1 irq after reset", 32'(irq[31:0]), 32'h0);
        rd(8'h10, 32'hFFFF_FFFF, "R1 dir bank0");
        rd(8'h14, 32'h0, "R1 out bank0");
        rd(8'h34, 32'h0, "R1 status bank0");
        rd(8'h60, 32'h0000_007F, "R1 R9 dir bank2");

        // R3: direction and plain output writes
        wr(8'h10, 32'hFFFF_0000);
        wr(8'h14, 32'h0000_00A5);
        #1;
        chk("R3 oe low half", 32'(pin_oe[31:0]), 32'h0000_FFFF);
        chk("R3 pin_out", 32'(pin_out[31:0]), 32'h0000_00A5);

        // R4: set and clear aliases
        wr(8'h18, 32'h0000_0F00);
        rd(8'h14, 32'h0000_0FA5, "R4 set ORs");
        wr(8'h1C, 32'h0000_0005);
        rd(8'h14, 32'h0000_0FA0, "R4 clear masks");
        rd(8'h18, 32'h0000_0FA0, "R4 set alias reads out");
        rd(8'h1C, 32'h0000_0FA0, "R4 clear alias reads out");

        // R5: wired read-back, pin 5 driven high but pin level low
        #1;
        chk("R5 pin 5 driven", 32'(pin_out[5]), 32'h1);
        rd(8'h20, 32'h0, "R5 input reads pin level");

        // R5: synchronizer lag on pin 40 (bank1 bit 8)
        @(negedge clk);
        pin_in[40] = 1'b1; addr = 8'h48;
        #1; chk("R5 lag 0 edges", rdata, 32'h0);
        @(posedge clk); #1; chk("R5 lag 1 edge", rdata, 32'h0);
        @(posedge clk); #1; chk("R5 lag 2 edges", rdata, 32'h0000_0100);

        // R6, R7: rising enable on pin 41 (bank1 bit 9)
        wr(8'h4C, 32'h0000_0200);
        rd(8'h4C, 32'h0000_0200, "R6 rise enable set");
        rd(8'h50, 32'h0000_0200, "R6 rise clear alias reads enable");
        @(negedge clk);
        pin_in[41] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R7 irq not yet", 32'(irq[41]), 32'h0);
        @(posedge clk); #1;
        chk("R7 irq on third edge", 32'(irq[41]), 32'h1);
        rd(8'h5C, 32'h0000_0200, "R7 only enabled pin flagged");

        // R8: write-one-to-clear
        wr(8'h5C, 32'h0000_0100);
        rd(8'h5C, 32'h0000_0200, "R8 zero bit untouched");
        wr(8'h5C, 32'h0000_0200);
        #1;
        chk("R8 clear drops irq", 32'(irq[41]), 32'h0);

        // R6, R8: both edges enabled; clear collides with a falling event
        wr(8'h54, 32'h0000_0200);
        rd(8'h54, 32'h0000_0200, "R6 fall enable set");
        @(negedge clk);
        pin_in[41] = 1'b0;
        @(posedge clk); @(posedge clk);
        wr(8'h5C, 32'h0000_0200);
        #1;
        chk("R8 event beats clear", 32'(irq[41]), 32'h1);
        wr(8'h5C, 32'h0000_0200);
        #1;
        chk("R8 later clear", 32'(irq[41]), 32'h0);
        wr(8'h50, 32'h0000_0200);
        rd(8'h4C, 32'h0, "R6 rise enable cleared");
        rd(8'h58, 32'h0000_0200, "R6 fall enable kept");

        // R2, R9: last bank, pin 70 is bank2 bit 6
        wr(8'h60, 32'h0);
        rd(8'h60, 32'h0, "R9 dir bank2 written");
        wr(8'h68, 32'hFFFF_FFFF);
        rd(8'h64, 32'h0000_007F, "R9 unused bits ignore set");
        #1;
        chk("R2 pin 70 driven", {30'h0, pin_out[70], pin_oe[70]}, 32'h3);
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, 32'h0000_007F, "R9 dir upper bits read zero");

        // R10: undefined offsets
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h88, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R10 below map");
        rd(8'h0C, 32'h0, "R10 just below map");
        rd(8'h88, 32'h0, "R10 just above map");
        rd(8'hFC, 32'h0, "R10 top of space");
        #1;
        chk("R10 outputs untouched", 32'(pin_oe[31:0]), 32'h0000_FFFF);

        repeat (4) @(posedge clk);
        #1;
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule